// File: doc/BRIEF.md
# Invalidation Instruction Privilege Checker

This unit sits in the decode or execute stage of a core that supports a hypervisor. For each decoded instruction it decides whether one of three address-translation maintenance operations may execute in the current privilege mode. If the operation may not execute, the unit reports which exception to raise. The three operations are an address-range invalidate, a pre-invalidate ordering fence and a post-invalidate ordering fence. The address invalidate obeys the machine-level and guest-level trap-virtual-memory controls. The two ordering fences never look at either control. Any other instruction is always allowed.

The decision is computed combinationally from the inputs and registered once, so the verdict appears one clock after the instruction is presented. Exactly one of allow, illegal-instruction or virtual-instruction is raised for a valid instruction, and none is raised when no instruction is presented. Trap delivery, the invalidation work itself and storage of the control registers belong to other blocks.

Top module: `inval_priv_chk`

## Requirements
- R1: While `rst_n` is low, `allow`, `exc_illegal` and `exc_virtual` are all 0.
- R2: If `instr_vld` is 0 at a clock edge, all three outputs are 0 after that edge.
- R3: If `instr_vld` is 1 at a clock edge, exactly one of the three outputs is 1 after that edge. Every verdict is visible one cycle after its inputs.
- R4: In machine mode (`priv_virt`=0, `priv_lvl`=3), every class is allowed, whatever the two trap controls are.
- R5: A fence class (`instr_cls` bit 2 = pre-invalidate fence, bit 3 = post-invalidate fence) in user mode (`priv_virt`=0, `priv_lvl`=0) raises `exc_illegal`.
- R6: A fence class in virtual user mode (`priv_virt`=1, `priv_lvl`=0) raises `exc_virtual`.
- R7: A fence class in supervisor mode (`priv_lvl`=1, either `priv_virt`) is allowed, whatever `trap_vm` and `trap_vm_guest` are.
- R8: The address-invalidate class (`instr_cls` bit 1) raises `exc_illegal` in user mode and `exc_virtual` in virtual user mode.
- R9: The address-invalidate class in host supervisor mode (`priv_virt`=0, `priv_lvl`=1) raises `exc_illegal` when `trap_vm`=1 and is allowed when `trap_vm`=0. `trap_vm_guest` has no effect in this mode.
- R10: The address-invalidate class in virtual supervisor mode (`priv_virt`=1, `priv_lvl`=1) raises `exc_virtual` when `trap_vm_guest`=1 and is allowed when `trap_vm_guest`=0. `trap_vm` has no effect in this mode.
- R11: The other class (`instr_cls` bit 0) is allowed in every well-formed mode.
- R12: A malformed mode (`priv_lvl`=2 with either `priv_virt`, or `priv_virt`=1 with `priv_lvl`=3) raises `exc_illegal` for every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_vld | input | 1 | An instruction is presented this cycle |
| instr_cls | input | 4 | One-hot class: bit 0 other, bit 1 address invalidate, bit 2 pre-invalidate fence, bit 3 post-invalidate fence |
| priv_lvl | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| priv_virt | input | 1 | Virtualization mode bit |
| trap_vm | input | 1 | Machine-level trap-virtual-memory control |
| trap_vm_guest | input | 1 | Hypervisor-level trap-virtual-memory control for guests |
| allow | output | 1 | Instruction may execute |
| exc_illegal | output | 1 | Raise an illegal-instruction exception |
| exc_virtual | output | 1 | Raise a virtual-instruction exception |

## Verification
The assertions assume that `instr_cls` has at most one bit set whenever `instr_vld` is high. A separate property flags any violation of that assumption rather than treating the case as defined behaviour. The stimulus only ever builds the class from a single shifted bit, and it sweeps every class across all four levels, both virtualization values and all four trap-control pairs. The remaining input combinations are driven only with `instr_vld` low, which the requirements leave free.

// File: rtl/inval_chk_pkg.sv
package inval_chk_pkg;

    parameter int CLS_W = 4;
    parameter int LVL_W = 2;

    localparam int CLS_OTHER = 0;
    localparam int CLS_ADDR  = 1;
    localparam int CLS_FPRE  = 2;
    localparam int CLS_FPOST = 3;

    localparam logic [LVL_W-1:0] LVL_USER = LVL_W'(0);
    localparam logic [LVL_W-1:0] LVL_SUP  = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_RSV  = LVL_W'(2);
    localparam logic [LVL_W-1:0] LVL_MACH = LVL_W'(3);

    typedef enum logic [2:0] {
        MK_MACH  = 3'd0,
        MK_HSUP  = 3'd1,
        MK_USER  = 3'd2,
        MK_VSUP  = 3'd3,
        MK_VUSER = 3'd4,
        MK_BAD   = 3'd5
    } mode_kind_e;

    typedef struct packed {
        logic ok;
        logic ill;
        logic vir;
    } verdict_t;

endpackage

// File: rtl/inval_mode_dec.sv
module inval_mode_dec
    import inval_chk_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  logic             virt,
    output mode_kind_e       kind
);

    always_comb begin
        kind = MK_BAD;
        unique case (lvl)
            LVL_USER: kind = virt ? MK_VUSER : MK_USER;
            LVL_SUP:  kind = virt ? MK_VSUP  : MK_HSUP;
            LVL_MACH: kind = virt ? MK_BAD   : MK_MACH;
            default:  kind = MK_BAD;
        endcase
    end

endmodule

// File: rtl/inval_rule.sv
module inval_rule
    import inval_chk_pkg::*;
(
    input  logic             vld,
    input  logic [CLS_W-1:0] cls,
    input  mode_kind_e       kind,
    input  logic             tvm,
    input  logic             gtvm,
    output verdict_t         verdict
);

    logic is_addr;
    logic is_fence;

    assign is_addr  = cls[CLS_ADDR];
    assign is_fence = cls[CLS_FPRE] | cls[CLS_FPOST];

    always_comb begin
        verdict = '0;
        if (vld) begin
            verdict.ok = 1'b1;
            unique case (kind)
                MK_MACH: ;
                MK_HSUP: begin
                    if (is_addr && tvm) begin
                        verdict = '{ok: 1'b0, ill: 1'b1, vir: 1'b0};
                    end
                end
                MK_VSUP: begin
                    if (is_addr && gtvm) begin
                        verdict = '{ok: 1'b0, ill: 1'b0, vir: 1'b1};
                    end
                end
                MK_USER: begin
                    if (is_addr || is_fence) begin
                        verdict = '{ok: 1'b0, ill: 1'b1, vir: 1'b0};
                    end
                end
                MK_VUSER: begin
                    if (is_addr || is_fence) begin
                        verdict = '{ok: 1'b0, ill: 1'b0, vir: 1'b1};
                    end
                end
                default: verdict = '{ok: 1'b0, ill: 1'b1, vir: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/inval_priv_chk.sv
module inval_priv_chk
    import inval_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_vld,
    input  logic [CLS_W-1:0] instr_cls,
    input  logic [LVL_W-1:0] priv_lvl,
    input  logic             priv_virt,
    input  logic             trap_vm,
    input  logic             trap_vm_guest,
    output logic             allow,
    output logic             exc_illegal,
    output logic             exc_virtual
);

    typedef struct packed {
        verdict_t v;
    } state_t;

    mode_kind_e kind;
    verdict_t   verdict;
    state_t     st_d;
    state_t     st_q;

    inval_mode_dec u_dec (
        .lvl  (priv_lvl),
        .virt (priv_virt),
        .kind (kind)
    );

    inval_rule u_rule (
        .vld     (instr_vld),
        .cls     (instr_cls),
        .kind    (kind),
        .tvm     (trap_vm),
        .gtvm    (trap_vm_guest),
        .verdict (verdict)
    );

    always_comb begin
        st_d   = st_q;
        st_d.v = verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign allow       = st_q.v.ok;
    assign exc_illegal = st_q.v.ill;
    assign exc_virtual = st_q.v.vir;

    logic fence_in;
    assign fence_in = instr_cls[CLS_FPRE] | instr_cls[CLS_FPOST];

    a_cls_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        instr_vld |-> $onehot0(instr_cls));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !(allow | exc_illegal | exc_virtual));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld |=> !(allow | exc_illegal | exc_virtual));

    a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        instr_vld |=> ($countones({allow, exc_illegal, exc_virtual}) == 1));

    a_r4_mach_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && !priv_virt && priv_lvl == LVL_MACH) |=> allow);

    a_r5_fence_user: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && fence_in && !priv_virt && priv_lvl == LVL_USER) |=> exc_illegal);

    a_r6_fence_vuser: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && fence_in && priv_virt && priv_lvl == LVL_USER) |=> exc_virtual);

    a_r7_fence_sup: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && fence_in && priv_lvl == LVL_SUP) |=> allow);

    a_r9_addr_hsup: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && instr_cls[CLS_ADDR] && !priv_virt && priv_lvl == LVL_SUP)
        |=> (exc_illegal == $past(trap_vm)));

    a_r10_addr_vsup: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && instr_cls[CLS_ADDR] && priv_virt && priv_lvl == LVL_SUP)
        |=> (exc_virtual == $past(trap_vm_guest)));

    a_r12_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && (priv_lvl == LVL_RSV || (priv_virt && priv_lvl == LVL_MACH)))
        |=> exc_illegal);

endmodule

// File: tb/inval_priv_chk_bench.sv
module inval_priv_chk_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_vld = 1'b0;
    logic [3:0] instr_cls = 4'b0001;
    logic [1:0] priv_lvl = 2'd0;
    logic       priv_virt = 1'b0;
    logic       trap_vm = 1'b0;
    logic       trap_vm_guest = 1'b0;
    logic       allow;
    logic       exc_illegal;
    logic       exc_virtual;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inval_priv_chk u_inval_priv_chk (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_vld     (instr_vld),
        .instr_cls     (instr_cls),
        .priv_lvl      (priv_lvl),
        .priv_virt     (priv_virt),
        .trap_vm       (trap_vm),
        .trap_vm_guest (trap_vm_guest),
        .allow         (allow),
        .exc_illegal   (exc_illegal),
        .exc_virtual   (exc_virtual)
    );

    // vld, cls[4], lvl[2], virt, tvm, gtvm, expected {allow, ill, vir}
    localparam logic [12:0] VEC [0:15] = '{
        {1'b1, 4'b0010, 2'd1, 1'b0, 1'b1, 1'b0, 3'b010},
        {1'b1, 4'b0010, 2'd1, 1'b0, 1'b0, 1'b1, 3'b100},
        {1'b1, 4'b0010, 2'd1, 1'b1, 1'b0, 1'b1, 3'b001},
        {1'b1, 4'b0010, 2'd1, 1'b1, 1'b1, 1'b0, 3'b100},
        {1'b1, 4'b0100, 2'd1, 1'b0, 1'b1, 1'b1, 3'b100},
        {1'b1, 4'b1000, 2'd1, 1'b1, 1'b1, 1'b1, 3'b100},
        {1'b1, 4'b0100, 2'd0, 1'b0, 1'b0, 1'b0, 3'b010},
        {1'b1, 4'b1000, 2'd0, 1'b1, 1'b0, 1'b0, 3'b001},
        {1'b1, 4'b0010, 2'd0, 1'b0, 1'b0, 1'b0, 3'b010},
        {1'b1, 4'b0010, 2'd0, 1'b1, 1'b0, 1'b0, 3'b001},
        {1'b1, 4'b0010, 2'd3, 1'b0, 1'b1, 1'b1, 3'b100},
        {1'b1, 4'b0001, 2'd0, 1'b1, 1'b1, 1'b1, 3'b100},
        {1'b1, 4'b0001, 2'd2, 1'b0, 1'b0, 1'b0, 3'b010},
        {1'b1, 4'b1000, 2'd3, 1'b1, 1'b0, 1'b0, 3'b010},
        {1'b0, 4'b0010, 2'd0, 1'b0, 1'b0, 1'b0, 3'b000},
        {1'b0, 4'b0100, 2'd1, 1'b1, 1'b1, 1'b1, 3'b000}
    };

    function automatic logic [2:0] model(input logic v, input logic [3:0] c,
                                         input logic [1:0] l, input logic vt,
                                         input logic tm, input logic gm);
        logic fence;
        fence = c[2] | c[3];
        if (!v) return 3'b000;                                  // R2
        if (l == 2'd2 || (vt && l == 2'd3)) return 3'b010;     // R12
        if (l == 2'd3) return 3'b100;                           // R4
        if (c[0]) return 3'b100;                                // R11
        if (l == 2'd0) return vt ? 3'b001 : 3'b010;             // R5 R6 R8
        if (fence) return 3'b100;                               // R7
        if (vt) return gm ? 3'b001 : 3'b100;                    // R10
        return tm ? 3'b010 : 3'b100;                            // R9
    endfunction

    function automatic string tag_of(input logic v, input logic [3:0] c,
                                     input logic [1:0] l, input logic vt);
        if (!v) return "R2";
        if (l == 2'd2 || (vt && l == 2'd3)) return "R12";
        if (l == 2'd3) return "R4";
        if (c[0]) return "R11";
        if (c[1]) return (l == 2'd0) ? "R8" : (vt ? "R10" : "R9");
        if (l == 2'd0) return vt ? "R6" : "R5";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [2:0] exp);
        checks++;
        if ({allow, exc_illegal, exc_virtual} !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag,
                     {allow, exc_illegal, exc_virtual}, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [3:0] c, input logic [1:0] l,
                         input logic vt, input logic tm, input logic gm);
        @(negedge clk);
        instr_vld = v; instr_cls = c; priv_lvl = l;
        priv_virt = vt; trap_vm = tm; trap_vm_guest = gm;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs low while reset holds, even with a valid instruction
        instr_vld = 1'b1; instr_cls = 4'b0010; priv_lvl = 2'd0;
        repeat (3) @(negedge clk);
        check("R1", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 16; i++) begin
            logic [12:0] e;
            e = VEC[i];
            apply(e[12], e[11:8], e[7:6], e[5], e[4], e[3]);
            check(tag_of(e[12], e[11:8], e[7:6], e[5]), e[2:0]);
        end

        // Exhaustive sweep, R3 one verdict per valid instruction
        for (int l = 0; l < 4; l++) begin
            for (int vt = 0; vt < 2; vt++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int tg = 0; tg < 4; tg++) begin
                        logic [3:0] cl;
                        cl = 4'b0001 << c;
                        apply(1'b1, cl, 2'(l), 1'(vt), tg[0], tg[1]);
                        check(tag_of(1'b1, cl, 2'(l), 1'(vt)),
                              model(1'b1, cl, 2'(l), 1'(vt), tg[0], tg[1]));
                        checks++;
                        if ($countones({allow, exc_illegal, exc_virtual}) != 1) begin
                            errors++;
                            $display("FAIL R3: got %b expected one bit set",
                                     {allow, exc_illegal, exc_virtual});
                        end
                    end
                end
            end
        end

        // R3 latency: a verdict change appears exactly one edge later
        @(negedge clk);
        instr_vld = 1'b1; instr_cls = 4'b0100; priv_lvl = 2'd0; priv_virt = 1'b0;
        @(negedge clk);
        check("R3", 3'b010);
        priv_lvl = 2'd1;
        check("R3", 3'b010);
        @(negedge clk);
        check("R3", 3'b100);

        // R2: valid drops to 0, outputs clear on the next edge
        instr_vld = 1'b0;
        @(negedge clk);
        check("R2", 3'b000);

        // R1: asynchronous reset clears a held verdict
        instr_vld = 1'b1; instr_cls = 4'b0010; priv_lvl = 2'd0;
        @(negedge clk);
        check("R8", 3'b010);
        rst_n = 1'b0;
        #1;
        check("R1", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        instr_vld = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule